// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block chooses which of ten interrupt vectors is presented to a processor. Each vector gathers a small group of request sources through an OR, so one vector can serve several peripherals. Each vector also carries a priority of low, high or highest. Only the first two vectors may use highest. The arbiter raises a request to the processor with the address of the winning vector. An acknowledge from the processor records the granted level as in service. A return strobe releases the most recent level.

Nesting follows a three-bit in-service mask with one bit per level. A pending vector can interrupt only when its level is strictly above the highest level already in service. Requests at an equal or lower level wait until that level is released. Among several pending vectors, the higher level wins. When levels tie, the lower vector number wins.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every vector is low priority, nothing is in service, `irq` is 0 and `vec_addr` is 0.
- R2: Vector v (0-based, 0..9) is pending when any bit of `src_req[v*4 +: 4]` is 1.
- R3: A write with `cfg_we`=1 sets the level of vector `cfg_vec`. For vectors 0 and 1, `cfg_lvl`=00 gives low and any other code gives highest. For vectors 2..9, `cfg_lvl`=00 gives low and any other code gives high.
- R4: When pending vectors differ in level, the one at the greater level wins. The order is highest > high > low.
- R5: Among pending vectors at the winning level, the lowest vector number wins.
- R6: While `irq` is 1, `vec_addr` equals 3 + 8*v for winning vector v. While `irq` is 0, `vec_addr` is 0.
- R7: `irq` is 1 exactly when some vector is pending and the winning level is strictly above the highest in-service level. If nothing is in service, any pending vector qualifies.
- R8: `ack` in a cycle with `irq`=1 marks the winner's level as in service from the next cycle. `ack` while `irq`=0 changes nothing.
- R9: `reti` removes the highest in-service level from the next cycle. `reti` with nothing in service changes nothing.
- R10: When `ack` (with `irq`=1) and `reti` fall in the same cycle, both take effect: the top level is removed and the granted level is added.
- R11: A write with `cfg_vec` of 10 or more changes no vector's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 40 | Request sources, four per vector |
| cfg_we | input | 1 | Priority write strobe |
| cfg_vec | input | 4 | Vector index for the write |
| cfg_lvl | input | 2 | Requested priority code |
| ack | input | 1 | Processor acknowledge of the presented vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Interrupt request to the processor |
| vec_addr | output | 20 | Address of the granted vector, 0 when idle |

## Verification
On every cycle, the assertions check four things:
- an acknowledge grows the in-service mask by one level, and an acknowledge without a request leaves it alone;
- a return shrinks a non-empty mask by one level;
- the first two vectors never hold the high code, and the other vectors never hold the highest code;
- the address is zero whenever no request is raised, and a raised request always points at a vector that is actually pending.

Some behaviours can only be shown by the bench's scenarios, using its reference model:
- which vector wins across mixed levels and ties;
- that an equal-level request is held off until a return;
- the combined acknowledge-and-return cycle;
- that a write to an index past the last vector has no effect.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NVEC   = 10,
  parameter int NSRC   = 4,
  parameter int NTOP   = 2,
  parameter int AW     = 20,
  parameter int BASE   = 3,
  parameter int STRIDE = 8,
  localparam int VW    = $clog2(NVEC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NVEC*NSRC-1:0] src_req,
  input  logic                 cfg_we,
  input  logic [VW-1:0]        cfg_vec,
  input  logic [1:0]           cfg_lvl,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 irq,
  output logic [AW-1:0]        vec_addr
);

  // level codes: 0 low, 1 high, 2 highest; rank = code + 1, 0 means none
  logic [1:0]    lvl_q [NVEC];
  logic [NVEC-1:0] pend;
  logic [2:0]    isr_q, isr_d, top_mask, set_mask;
  logic [1:0]    best, top;
  logic [VW-1:0] win;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    assign pend[v] = |src_req[v*NSRC +: NSRC];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        lvl_q[v] <= 2'd0;
      else if (cfg_we && cfg_vec == VW'(v))
        lvl_q[v] <= (v < NTOP) ? {|cfg_lvl, 1'b0} : {1'b0, |cfg_lvl};

    if (v < NTOP) begin : g_top
      // R3
      always @(posedge clk) begin
        top_code_chk: assert (!rst_n || lvl_q[v] != 2'd1);
      end
    end else begin : g_rest
      // R3
      always @(posedge clk) begin
        coerce_chk: assert (!rst_n || lvl_q[v] != 2'd2);
      end
    end
  end

  always_comb begin
    best = 2'd0;
    win  = '0;
    for (int v = 0; v < NVEC; v++)
      if (pend[v] && (lvl_q[v] + 2'd1) > best) begin
        best = lvl_q[v] + 2'd1;
        win  = VW'(v);
      end
  end

  assign top      = isr_q[2] ? 2'd3 : isr_q[1] ? 2'd2 : isr_q[0] ? 2'd1 : 2'd0;
  assign top_mask = isr_q[2] ? 3'b100 : isr_q[1] ? 3'b010 : isr_q[0] ? 3'b001 : 3'b000;
  assign irq      = best > top;
  assign vec_addr = irq ? AW'(BASE) + AW'(STRIDE) * AW'(win) : '0;
  assign set_mask = (ack && irq) ? (3'b001 << (best - 2'd1)) : 3'b000;
  assign isr_d    = (reti ? (isr_q & ~top_mask) : isr_q) | set_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) isr_q <= 3'b000;
    else        isr_q <= isr_d;

  // R8
  ack_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq && !reti |=> $countones(isr_q) == $past($countones(isr_q)) + 1);

  // R8
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !irq && !reti |=> isr_q == $past(isr_q));

  // R9
  reti_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !ack && (isr_q != 3'b000) |=> $countones(isr_q) == $past($countones(isr_q)) - 1);

  // R6
  addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> vec_addr == '0);

  // R2
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend[win]);

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [39:0] src_req = '0;
  logic        cfg_we = 0, ack = 0, reti = 0;
  logic [3:0]  cfg_vec = '0;
  logic [1:0]  cfg_lvl = '0;
  logic        irq;
  logic [19:0] vec_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  int lvl [10];
  int isr [3];
  int e_irq, e_addr, e_best;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (.clk, .rst_n, .src_req, .cfg_we, .cfg_vec, .cfg_lvl,
                    .ack, .reti, .irq, .vec_addr);

  function automatic void expect_now();
    int best = -1, win = 0, top = -1;
    for (int v = 0; v < 10; v++)
      if ((|src_req[v*4 +: 4]) && lvl[v] > best) begin best = lvl[v]; win = v; end
    for (int l = 0; l < 3; l++) if (isr[l] != 0) top = l;
    e_best = best;
    e_irq  = (best >= 0 && best > top) ? 1 : 0;
    e_addr = e_irq ? 3 + 8 * win : 0;
  endfunction

  task automatic cyc(string tag);
    int top = -1;
    #2;
    expect_now();
    checks++;
    if (irq !== e_irq[0] || vec_addr !== e_addr[19:0]) begin
      fails++;
      $display("FAIL %s irq=%0b/%0d addr=%0d/%0d", tag, irq, e_irq, vec_addr, e_addr);
    end
    @(posedge clk);
    if (cfg_we && cfg_vec < 10)
      lvl[cfg_vec] = (cfg_lvl == 0) ? 0 : (cfg_vec < 2) ? 2 : 1;
    for (int l = 0; l < 3; l++) if (isr[l] != 0) top = l;
    if (reti && top >= 0) isr[top] = 0;
    if (ack && e_irq == 1) isr[e_best] = 1;
    @(negedge clk);
  endtask

  task automatic idle();
    src_req = '0; cfg_we = 0; ack = 0; reti = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 10; v++) lvl[v] = 0;
    for (int l = 0; l < 3; l++) isr[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R1 reset state");
    src_req[4*4+2] = 1;                 cyc("R2 single source, addr 35");
    idle(); src_req[3*4] = 1; src_req[6*4+3] = 1; cyc("R5 tie low, addr 27");
    idle(); cfg_we = 1; cfg_vec = 6; cfg_lvl = 2'b01; cyc("R3 write high");
    idle(); src_req[3*4] = 1; src_req[6*4+1] = 1; cyc("R4 high beats low, addr 51");
    idle(); cfg_we = 1; cfg_vec = 12; cfg_lvl = 2'b10; cyc("R11 out of range write");
    idle(); cfg_we = 1; cfg_vec = 2; cfg_lvl = 2'b10; cyc("R3 coerced write");
    idle(); src_req[1*4] = 1; src_req[2*4] = 1; ack = 1; cyc("R3 coerced to high, addr 19");
    idle(); src_req[6*4] = 1; cyc("R7 equal level postponed");
    idle(); ack = 1; cyc("R8 ack without request");
    idle(); src_req[6*4] = 1; cyc("R8 state unchanged after idle ack");
    idle(); cfg_we = 1; cfg_vec = 1; cfg_lvl = 2'b01; cyc("R3 top vector write");
    idle(); src_req[1*4+3] = 1; ack = 1; reti = 1; cyc("R10 ack and return together, addr 11");
    idle(); src_req[6*4] = 1; src_req[1*4] = 1; cyc("R7 held under highest");
    idle(); reti = 1; cyc("R9 return");
    idle(); src_req[6*4] = 1; cyc("R9 released, addr 51");
    idle(); reti = 1; cyc("R9 return on empty");
    idle(); reti = 1; cyc("R9 second return");
    idle(); src_req[0] = 1; cyc("R6 vector 0 addr 3");
    for (int n = 0; n < 4000; n++) begin
      idle();
      for (int b = 0; b < 40; b++) src_req[b] = ($urandom % 20) == 0;
      cfg_we  = ($urandom % 8) == 0;
      cfg_vec = 4'($urandom % 16);
      cfg_lvl = 2'($urandom % 4);
      ack     = ($urandom % 3) == 0;
      reti    = ($urandom % 5) == 0;
      cyc("R4 R5 R7 R11 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule